// File: doc/BRIEF.md
# Arithmetic Unit with Sign-Exact Condition Flags

This block is the add/subtract slice of an integer datapath. Each cycle it may accept two 32-bit operands and an operation code. It then produces a registered result and four condition flags: zero, carry, negative and overflow. A compare runs the same subtraction as a subtract. It updates only the flags: the result register keeps its value and no write is requested, so a downstream register file leaves its contents alone.

The negative flag reports the sign of the mathematically exact result rather than the top bit of the wrapped 32-bit value. When a signed overflow flips the stored top bit, the negative flag flips it back. A signed "less than" test after a compare is then a plain read of the negative flag, with no N-versus-V comparison downstream.

Outputs change one clock after an accepted operation. With the valid strobe low the outputs hold their values, and a synchronous reset clears them.

Top module: `arith_flag_unit`

## Requirements
- R1: With in_valid high and op = 2'b00 (add), at the next rising edge result becomes (a + b) mod 2^32 and wr_en is 1 for that one cycle.
- R2: With in_valid high and op = 2'b01 (subtract), at the next rising edge result becomes (a - b) mod 2^32 and wr_en is 1 for that one cycle.
- R3: With in_valid high and op = 2'b10 (compare), the flags are updated from a - b, result keeps its previous value and wr_en stays 0.
- R4: flag_z is 1 exactly when the 32-bit wrapped value of the operation (sum or difference) is zero.
- R5: flag_c is the unsigned carry out of a + b for add; for subtract and compare it is 1 exactly when a >= b taken as unsigned numbers.
- R6: flag_v is 1 exactly when the signed two's-complement result does not fit in 32 bits.
- R7: flag_n is 1 exactly when the exact signed result (computed without wrap) is negative, including when flag_v is 1; for compare this means flag_n = 1 exactly when signed a < signed b.
- R8: With in_valid low, result and all flags keep their values and wr_en is 0 at the next edge.
- R9: The code op = 2'b11 is reserved: with in_valid high it leaves result and flags unchanged and wr_en is 0.
- R10: With rst high at a rising edge, result, all four flags and wr_en are 0 after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Accept the operation presented this cycle |
| op | input | 2 | 00 add, 01 subtract, 10 compare, 11 reserved |
| a | input | 32 | First operand |
| b | input | 32 | Second operand (subtrahend) |
| result | output | 32 | Registered sum or difference |
| wr_en | output | 1 | One-cycle pulse when result holds a new value |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry / no-borrow flag |
| flag_n | output | 1 | Sign of the exact result |
| flag_v | output | 1 | Signed overflow flag |

## Verification
The bench goes after the operand pairs where the wrapped top bit lies about the sign. Examples are the most negative value minus the most positive, the most negative value added to itself, and the most positive value plus one. A design that copies the raw top bit into flag_n would report the wrong ordering for these pairs and would clear N when two large negatives overflow to zero. Carry is checked at equal operands and around the unsigned wrap, where an inverted borrow convention flips C. Compare, idle and reserved cycles are each followed by a read of the held result and wr_en, which exposes a design that writes on compare or decodes the spare code as a subtract.

// File: rtl/arith_flag_pkg.sv
package arith_flag_pkg;

    typedef enum logic [1:0] {
        OP_ADD = 2'b00,
        OP_SUB = 2'b01,
        OP_CMP = 2'b10,
        OP_RSV = 2'b11
    } arith_op_e;

    typedef struct packed {
        logic z;
        logic c;
        logic n;
        logic v;
    } cond_flags_t;

    localparam cond_flags_t FLAGS_CLEAR = '{z: 1'b0, c: 1'b0, n: 1'b0, v: 1'b0};

endpackage

// File: rtl/arith_addsub.sv
module arith_addsub #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] opa,
    input  logic [WIDTH-1:0] opb,
    input  logic             do_sub,
    output logic [WIDTH-1:0] sum,
    output logic             carry_out,
    output logic             sgn_ovf
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] opb_eff;
    logic [WIDTH:0]   wide_sum;

    always_comb begin
        // Subtraction as a + ~b + 1; carry out is then the no-borrow bit.
        opb_eff   = do_sub ? ~opb : opb;
        wide_sum  = {1'b0, opa} + {1'b0, opb_eff} + {{WIDTH{1'b0}}, do_sub};
        sum       = wide_sum[MSB:0];
        carry_out = wide_sum[WIDTH];
        // Overflow: effective operands agree in sign, result disagrees.
        sgn_ovf   = (opa[MSB] == opb_eff[MSB]) && (sum[MSB] != opa[MSB]);
    end
endmodule

// File: rtl/arith_flags.sv
module arith_flags
    import arith_flag_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] sum,
    input  logic             carry_out,
    input  logic             sgn_ovf,
    output cond_flags_t      flags
);
    localparam int MSB = WIDTH - 1;

    always_comb begin
        flags.z = ~|sum;
        flags.c = carry_out;
        // Undo the sign flip that overflow causes: true sign of exact result.
        flags.n = sum[MSB] ^ sgn_ovf;
        flags.v = sgn_ovf;
    end
endmodule

// File: rtl/arith_flag_unit.sv
module arith_flag_unit
    import arith_flag_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [1:0]       op,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic [WIDTH-1:0] result,
    output logic             wr_en,
    output logic             flag_z,
    output logic             flag_c,
    output logic             flag_n,
    output logic             flag_v
);
    localparam int MSB = WIDTH - 1;

    typedef struct packed {
        logic [WIDTH-1:0] result;
        cond_flags_t      flags;
        logic             wr;
    } unit_state_t;

    arith_op_e   op_sel;
    logic        sub_sel;
    logic [WIDTH-1:0] sum_w;
    logic        cout_w;
    logic        ovf_w;
    cond_flags_t flags_w;
    unit_state_t st_d;
    unit_state_t st_q;

    assign op_sel  = arith_op_e'(op);
    assign sub_sel = (op_sel != OP_ADD);

    arith_addsub #(.WIDTH(WIDTH)) u_addsub (
        .opa       (a),
        .opb       (b),
        .do_sub    (sub_sel),
        .sum       (sum_w),
        .carry_out (cout_w),
        .sgn_ovf   (ovf_w)
    );

    arith_flags #(.WIDTH(WIDTH)) u_flags (
        .sum       (sum_w),
        .carry_out (cout_w),
        .sgn_ovf   (ovf_w),
        .flags     (flags_w)
    );

    always_comb begin
        st_d    = st_q;
        st_d.wr = 1'b0;
        if (in_valid) begin
            unique case (op_sel)
                OP_ADD, OP_SUB: begin
                    st_d.result = sum_w;
                    st_d.flags  = flags_w;
                    st_d.wr     = 1'b1;
                end
                OP_CMP: begin
                    st_d.flags  = flags_w;
                end
                default: begin
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '{result: '0, flags: FLAGS_CLEAR, wr: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign result = st_q.result;
    assign wr_en  = st_q.wr;
    assign flag_z = st_q.flags.z;
    assign flag_c = st_q.flags.c;
    assign flag_n = st_q.flags.n;
    assign flag_v = st_q.flags.v;

    // R3
    cmp_no_write_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == 2'b10) |=> (!wr_en && $stable(result)));

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!wr_en && $stable(result) && $stable({flag_z, flag_c, flag_n, flag_v})));

    // R9
    rsv_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == 2'b11) |=> (!wr_en && $stable(result) && $stable({flag_z, flag_c, flag_n, flag_v})));

    // R4
    zero_match_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (flag_z == (result == '0)));

    // R5
    borrow_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (op == 2'b01 || op == 2'b10)) |=> (flag_c == ($past(a) >= $past(b))));

    // R7
    add_sign_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == 2'b00 && a[MSB] == b[MSB]) |=> (flag_n == $past(a[MSB])));

    // R7
    sub_sign_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (op == 2'b01 || op == 2'b10) && a[MSB] != b[MSB]) |=> (flag_n == $past(a[MSB])));

    // R6
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == 2'b00 && a[MSB] != b[MSB]) |=> !flag_v);

    // R1
    write_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (op == 2'b00 || op == 2'b01)) |=> wr_en);
endmodule

// File: tb/tb_arith_flag_unit.sv
`timescale 1ns/1ps
module tb_arith_flag_unit;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [1:0]  op;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] result;
    logic        wr_en;
    logic        flag_z, flag_c, flag_n, flag_v;

    int checks = 0;
    int failures = 0;

    logic [31:0] exp_res;
    logic [3:0]  exp_flags; // {z,c,n,v}
    logic [31:0] lfsr = 32'h1234_5678;

    always #2 clk = ~clk;

    arith_flag_unit dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .a(a), .b(b),
        .result(result), .wr_en(wr_en),
        .flag_z(flag_z), .flag_c(flag_c), .flag_n(flag_n), .flag_v(flag_v)
    );

    initial begin
        repeat (100000) @(posedge clk);
        $display("FAIL watchdog expired");
        failures++;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] want);
        checks++;
        if (got !== want) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, got, want);
        end
    endtask

    // Reference from 33-bit exact signed arithmetic.
    task automatic model(input logic [1:0] o, input logic [31:0] x, input logic [31:0] y,
                         output logic [31:0] r, output logic [3:0] f);
        logic signed [32:0] ex;
        logic [32:0] uadd;
        logic c;
        if (o == 2'b00) begin
            ex   = $signed({x[31], x}) + $signed({y[31], y});
            uadd = {1'b0, x} + {1'b0, y};
            c    = uadd[32];
        end else begin
            ex = $signed({x[31], x}) - $signed({y[31], y});
            c  = (x >= y);
        end
        r = ex[31:0];
        f = {(ex[31:0] == 32'd0), c, ex[32], (ex[32] != ex[31])};
    endtask

    task automatic drive(input logic v, input logic [1:0] o, input logic [31:0] x, input logic [31:0] y);
        @(negedge clk);
        in_valid = v; op = o; a = x; b = y;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic run_op(input string tag, input logic [1:0] o, input logic [31:0] x, input logic [31:0] y);
        logic [31:0] r;
        logic [3:0]  f;
        model(o, x, y, r, f);
        drive(1'b1, o, x, y);
        exp_flags = f;
        if (o != 2'b10) exp_res = r;
        check({tag, " result"}, result, exp_res);
        check({tag, " wr_en"}, {31'd0, wr_en}, {31'd0, (o != 2'b10)});
        check({tag, " flags zcnv"}, {28'd0, flag_z, flag_c, flag_n, flag_v}, {28'd0, exp_flags});
    endtask

    task automatic t_reset();
        rst = 1'b1; in_valid = 1'b1; op = 2'b00; a = 32'h5; b = 32'h7;
        @(negedge clk); @(negedge clk);
        rst = 1'b0; in_valid = 1'b0;
        exp_res = '0; exp_flags = '0;
        check("R10 result", result, 32'd0);
        check("R10 wr_en+flags", {27'd0, wr_en, flag_z, flag_c, flag_n, flag_v}, 32'd0);
    endtask

    task automatic t_add();
        run_op("R1 add small", 2'b00, 32'd100, 32'd23);
        run_op("R6 R7 add max+1", 2'b00, 32'h7FFF_FFFF, 32'd1);
        run_op("R7 R6 add min+min", 2'b00, 32'h8000_0000, 32'h8000_0000);
        run_op("R5 R4 add wrap to zero", 2'b00, 32'hFFFF_FFFF, 32'd1);
        run_op("R5 add neg+neg", 2'b00, 32'hFFFF_FFF0, 32'hFFFF_FF00);
    endtask

    task automatic t_sub();
        run_op("R2 sub small", 2'b01, 32'd50, 32'd80);
        run_op("R7 R6 sub min-max", 2'b01, 32'h8000_0000, 32'h7FFF_FFFF);
        run_op("R7 R6 sub max-min", 2'b01, 32'h7FFF_FFFF, 32'h8000_0000);
        run_op("R4 R5 sub equal", 2'b01, 32'hDEAD_BEEF, 32'hDEAD_BEEF);
        run_op("R5 sub zero-one", 2'b01, 32'd0, 32'd1);
    endtask

    task automatic t_cmp();
        run_op("R1 seed before cmp", 2'b00, 32'h1111_1111, 32'h2222_2222);
        run_op("R3 R7 cmp min<max", 2'b10, 32'h8000_0000, 32'h7FFF_FFFF);
        run_op("R3 R7 cmp max>min", 2'b10, 32'h7FFF_FFFF, 32'h8000_0000);
        run_op("R3 R4 cmp equal", 2'b10, 32'h0000_0042, 32'h0000_0042);
        run_op("R3 R7 cmp -1<0", 2'b10, 32'hFFFF_FFFF, 32'd0);
    endtask

    task automatic t_idle();
        @(negedge clk);
        in_valid = 1'b0; op = 2'b00; a = 32'h1; b = 32'h1;
        @(negedge clk);
        check("R8 idle result", result, exp_res);
        check("R8 idle wr_en+flags", {27'd0, wr_en, flag_z, flag_c, flag_n, flag_v}, {27'd0, 1'b0, exp_flags});
    endtask

    task automatic t_reserved();
        drive(1'b1, 2'b11, 32'h0, 32'h0);
        check("R9 rsv result", result, exp_res);
        check("R9 rsv wr_en+flags", {27'd0, wr_en, flag_z, flag_c, flag_n, flag_v}, {27'd0, 1'b0, exp_flags});
    endtask

    task automatic t_sweep();
        for (int i = 0; i < 60; i++) begin
            logic [31:0] x, y;
            lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
            x = lfsr;
            lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
            y = (i % 4 == 0) ? {~x[31], x[30:0]} : lfsr;
            run_op("R1 R2 R3 R5 R6 R7 sweep", 2'(i % 3), x, y);
        end
    endtask

    initial begin
        in_valid = 1'b0; op = 2'b00; a = '0; b = '0; rst = 1'b1;
        exp_res = '0; exp_flags = '0;
        t_reset();
        t_add();
        t_sub();
        t_cmp();
        t_idle();
        t_reserved();
        t_sweep();
        t_idle();
        t_reset();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule